// File: doc/BRIEF.md
# Four-Wire One-Hot Return-to-Zero Link

This block carries a parallel word across a link that has no clock of its own. The word is cut into 2-bit symbols. Each symbol travels on its own group of four wires, and exactly one wire of the group is raised for each symbol value. The sending side and the receiving side are connected only by these data wires and one acknowledge wire. The receiver knows a word has arrived only because every group shows a complete code. Every transfer follows a four-phase cycle: code up, acknowledge up, spacer (all wires low), acknowledge down.

The design is modelled synchronously. The transmitter takes words from a valid/ready handshake. It drives the one-hot code and holds it until the acknowledge rises. It then returns every wire to low and waits for the acknowledge to fall before it accepts another word. The receiver checks every group for completion. When all groups hold one wire high, it latches the decoded word, pulses a valid strobe and raises the acknowledge. It drops the acknowledge once every wire is low again. A group with two or more wires high is never taken as data and sets a sticky error flag.

Both link sides are brought out as ports, so the integrator routes the wires between them (directly, through repeaters, or across a region boundary).

Top module: `qlink_top`

## Requirements
- R1: While reset is held and right after it, `in_ready` is 1, while `tx_lines`, `rx_ack`, `out_valid` and `err_flag` are all 0.
- R2: Symbol g of the word is bits [2g+1:2g] of `in_word`. It is sent on lines [4g+3:4g]. Symbol value s raises only line 4g+s of that group, so 00 raises bit 0, 01 bit 1, 10 bit 2 and 11 bit 3.
- R3: A word is taken only in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after acceptance until the transfer completes. The code appears on `tx_lines` one cycle after acceptance.
- R4: The transmitter holds its code unchanged for as long as `tx_ack` stays 0. It drives all lines to 0 one cycle after it samples `tx_ack` high.
- R5: After the spacer, the transmitter keeps `in_ready` at 0 while `tx_ack` is 1, even if `in_valid` is held high. `in_ready` returns to 1 one cycle after `tx_ack` is sampled low.
- R6: One cycle after every group of `rx_lines` holds exactly one high wire while `rx_ack` is 0, the receiver raises `rx_ack`, shows the decoded word on `out_word` and sets `out_valid` for that single cycle.
- R7: While any group of `rx_lines` is all low, the receiver does not raise `rx_ack` or `out_valid`.
- R8: `rx_ack` stays 1 while any line of `rx_lines` is high. It falls one cycle after all lines are low.
- R9: A group with two or more wires high sets `err_flag` one cycle later. The flag then stays 1 until reset. Such a code never raises `rx_ack` or `out_valid`.
- R10: With the two sides wired directly to each other, a new word can be accepted every five cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both link sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sender offers a word |
| in_ready | output | 1 | Transmitter can take a word |
| in_word | input | WIDTH | Word to send |
| tx_lines | output | 2*WIDTH | One-hot groups driven onto the link |
| tx_ack | input | 1 | Acknowledge seen by the transmitter |
| rx_lines | input | 2*WIDTH | One-hot groups arriving at the receiver |
| rx_ack | output | 1 | Acknowledge driven by the receiver |
| out_valid | output | 1 | One-cycle strobe for a received word |
| out_word | output | WIDTH | Last received word |
| err_flag | output | 1 | Sticky flag for a multi-hot group |

## Verification
Every result is registered, so each one has a fixed cycle when it is due. The code is due on the lines one edge after acceptance. With a direct loopback, the receiver strobe and acknowledge are due on the next edge, the spacer one edge after that, the acknowledge drop one edge later, and `in_ready` one edge after the drop. The bench drives inputs and samples outputs on falling edges. It walks through a transfer one falling edge at a time and checks each result in the exact half-cycle where it becomes visible. It also checks that nothing moves in the cycles just before that. For the stall, partial-code and multi-hot cases, the bench holds the link wires or the acknowledge itself. It then checks that the outputs stay unchanged for several cycles before releasing them.

// File: rtl/qlink_pkg.sv
package qlink_pkg;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_DRIVE = 2'd1,
      TX_RTZ   = 2'd2
   } tx_state_e;

   // 2-bit symbol to 4-wire one-hot group: value s raises wire s
   function automatic logic [3:0] sym_to_wires(input logic [1:0] sym);
      logic [3:0] w;
      w = 4'b0000;
      w[sym] = 1'b1;
      return w;
   endfunction

   // one-hot group back to its 2-bit symbol (meaningful only for one-hot input)
   function automatic logic [1:0] wires_to_sym(input logic [3:0] w);
      logic [1:0] s;
      s = 2'd0;
      if (w[1]) s = 2'd1;
      if (w[2]) s = 2'd2;
      if (w[3]) s = 2'd3;
      return s;
   endfunction

endpackage

// File: rtl/qlink_group_det.sv
module qlink_group_det
   import qlink_pkg::*;
(
   input  logic [3:0] wires,
   output logic       is_one,
   output logic       is_empty,
   output logic       is_multi,
   output logic [1:0] sym
);

   logic [2:0] hot_cnt;

   always_comb begin
      hot_cnt = {2'b00, wires[0]} + {2'b00, wires[1]}
              + {2'b00, wires[2]} + {2'b00, wires[3]};
   end

   assign is_one   = (hot_cnt == 3'd1);
   assign is_empty = (hot_cnt == 3'd0);
   assign is_multi = (hot_cnt > 3'd1);
   assign sym      = wires_to_sym(wires);

endmodule

// File: rtl/qlink_tx.sv
module qlink_tx
   import qlink_pkg::*;
#(
   parameter int WIDTH = 32
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [WIDTH-1:0]     in_word,
   output logic [2*WIDTH-1:0]   tx_lines,
   input  logic                 tx_ack
);

   localparam int GROUPS = WIDTH / 2;
   localparam int LINES  = 4 * GROUPS;

   tx_state_e          state_q, state_d;
   logic [LINES-1:0]   lines_q, lines_d;
   logic [LINES-1:0]   code_w;

   generate
      for (genvar g = 0; g < GROUPS; g++) begin : g_enc
         assign code_w[4*g +: 4] = sym_to_wires(in_word[2*g +: 2]);
      end
   endgenerate

   assign in_ready = (state_q == TX_IDLE) && !tx_ack;
   assign tx_lines = lines_q;

   always_comb begin
      state_d = state_q;
      lines_d = lines_q;
      case (state_q)
         TX_IDLE: begin
            if (in_valid && in_ready) begin
               lines_d = code_w;
               state_d = TX_DRIVE;
            end
         end
         TX_DRIVE: begin
            if (tx_ack) begin
               lines_d = '0;
               state_d = TX_RTZ;
            end
         end
         TX_RTZ: begin
            if (!tx_ack) state_d = TX_IDLE;
         end
         default: begin
            lines_d = '0;
            state_d = TX_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         lines_q <= '0;
      end else begin
         state_q <= state_d;
         lines_q <= lines_d;
      end
   end

endmodule

// File: rtl/qlink_rx.sv
module qlink_rx
   import qlink_pkg::*;
#(
   parameter int WIDTH = 32
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*WIDTH-1:0]   rx_lines,
   output logic                 rx_ack,
   output logic                 out_valid,
   output logic [WIDTH-1:0]     out_word,
   output logic                 err_flag
);

   localparam int GROUPS = WIDTH / 2;

   logic [GROUPS-1:0]  one_v, empty_v, multi_v;
   logic [WIDTH-1:0]   sym_v;
   logic               all_one, all_empty, any_multi;

   generate
      for (genvar g = 0; g < GROUPS; g++) begin : g_det
         qlink_group_det u_det (
            .wires    (rx_lines[4*g +: 4]),
            .is_one   (one_v[g]),
            .is_empty (empty_v[g]),
            .is_multi (multi_v[g]),
            .sym      (sym_v[2*g +: 2])
         );
      end
   endgenerate

   assign all_one   = &one_v;
   assign all_empty = &empty_v;
   assign any_multi = |multi_v;

   logic             ack_q, valid_q, err_q;
   logic [WIDTH-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         word_q  <= '0;
      end else begin
         valid_q <= 1'b0;
         if (!ack_q && all_one) begin
            ack_q   <= 1'b1;
            valid_q <= 1'b1;
            word_q  <= sym_v;
         end else if (ack_q && all_empty) begin
            ack_q <= 1'b0;
         end
         if (any_multi) err_q <= 1'b1;
      end
   end

   assign rx_ack    = ack_q;
   assign out_valid = valid_q;
   assign out_word  = word_q;
   assign err_flag  = err_q;

endmodule

// File: rtl/qlink_top.sv
module qlink_top #(
   parameter int WIDTH = 32
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [WIDTH-1:0]     in_word,
   output logic [2*WIDTH-1:0]   tx_lines,
   input  logic                 tx_ack,
   input  logic [2*WIDTH-1:0]   rx_lines,
   output logic                 rx_ack,
   output logic                 out_valid,
   output logic [WIDTH-1:0]     out_word,
   output logic                 err_flag
);

   generate
      if (WIDTH < 2 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("qlink_top: WIDTH must be even and at least 2");
      end
   endgenerate

   qlink_tx #(.WIDTH(WIDTH)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_word  (in_word),
      .tx_lines (tx_lines),
      .tx_ack   (tx_ack)
   );

   qlink_rx #(.WIDTH(WIDTH)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_lines  (rx_lines),
      .rx_ack    (rx_ack),
      .out_valid (out_valid),
      .out_word  (out_word),
      .err_flag  (err_flag)
   );

endmodule

// File: rtl/qlink_check.sv
module qlink_check #(
   parameter int WIDTH = 32
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic [2*WIDTH-1:0]   tx_lines,
   input logic                 tx_ack,
   input logic [2*WIDTH-1:0]   rx_lines,
   input logic                 rx_ack,
   input logic                 out_valid,
   input logic                 err_flag
);

   localparam int GROUPS = WIDTH / 2;

   logic [GROUPS-1:0] grp_one, grp_multi;

   generate
      for (genvar g = 0; g < GROUPS; g++) begin : g_chk
         assign grp_one[g]   = ($countones(rx_lines[4*g +: 4]) == 1);
         assign grp_multi[g] = ($countones(rx_lines[4*g +: 4]) > 1);

         assert_tx_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(tx_lines[4*g +: 4]));
      end
   endgenerate

   assert_accept_from_spacer_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> (tx_lines == '0));

   assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_lines != '0) && !tx_ack) |=> $stable(tx_lines));

   assert_no_ready_in_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ack && (tx_lines == '0)) |=> !in_ready);

   assert_ack_rise_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ack) |-> $past(&grp_one));

   assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_ack_fall_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_ack) |-> $past(rx_lines == '0));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   assert_multi_no_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_ack && (|grp_multi)) |=> (!rx_ack && !out_valid && err_flag));

endmodule

bind qlink_top qlink_check #(.WIDTH(WIDTH)) u_check (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .tx_lines  (tx_lines),
   .tx_ack    (tx_ack),
   .rx_lines  (rx_lines),
   .rx_ack    (rx_ack),
   .out_valid (out_valid),
   .err_flag  (err_flag)
);

// File: tb/qlink_top_bench.sv
`timescale 1ns/1ps
module qlink_top_bench;

   localparam int W = 32;
   localparam int L = 2 * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [W-1:0]  in_word = '0;
   logic          in_ready;
   logic [L-1:0]  tx_lines;
   logic          tx_ack;
   logic [L-1:0]  rx_lines;
   logic          rx_ack;
   logic          out_valid;
   logic [W-1:0]  out_word;
   logic          err_flag;

   // link wiring with override points
   logic          inj_en = 1'b0;
   logic [L-1:0]  inj_val = '0;
   logic          ack_block = 1'b0;
   logic          ack_force = 1'b0;

   assign rx_lines = inj_en ? inj_val : tx_lines;
   assign tx_ack   = ack_block ? ack_force : rx_ack;

   always #2.5 clk = ~clk;

   qlink_top #(.WIDTH(W)) u_qlink_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_word   (in_word),
      .tx_lines  (tx_lines),
      .tx_ack    (tx_ack),
      .rx_lines  (rx_lines),
      .rx_ack    (rx_ack),
      .out_valid (out_valid),
      .out_word  (out_word),
      .err_flag  (err_flag)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic chk(input bit ok, input string tag,
                      input logic [L-1:0] act, input logic [L-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic eq(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
      chk(act === exp, tag, act, exp);
   endtask

   // expected wire pattern: symbol g -> lines [4g+3:4g], value s raises bit 4g+s
   function automatic logic [L-1:0] enc(input logic [W-1:0] w);
      logic [L-1:0] r;
      r = '0;
      for (int g = 0; g < W/2; g++) begin
         r[4*g + int'(w[2*g +: 2])] = 1'b1;
      end
      return r;
   endfunction

   // full loopback transfer, checked at every falling edge
   task automatic send_word(input logic [W-1:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      eq("R3 ready before accept", {63'd0, in_ready}, 64'd1);
      @(negedge clk);
      in_valid = 1'b0;
      eq("R3 ready drops after accept", {63'd0, in_ready}, 64'd0);
      eq("R2 code on lines", tx_lines, enc(w));
      eq("R6 no strobe yet", {63'd0, out_valid}, 64'd0);
      @(negedge clk);
      eq("R6 ack raised", {63'd0, rx_ack}, 64'd1);
      eq("R6 strobe", {63'd0, out_valid}, 64'd1);
      eq("R6 word", {32'd0, out_word}, {32'd0, w});
      eq("R4 code held", tx_lines, enc(w));
      @(negedge clk);
      eq("R4 spacer", tx_lines, '0);
      eq("R6 strobe one cycle", {63'd0, out_valid}, 64'd0);
      eq("R8 ack held", {63'd0, rx_ack}, 64'd1);
      @(negedge clk);
      eq("R8 ack dropped", {63'd0, rx_ack}, 64'd0);
      eq("R5 ready low", {63'd0, in_ready}, 64'd0);
      @(negedge clk);
      eq("R10 ready after five cycles", {63'd0, in_ready}, 64'd1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      eq("R1 ready in reset", {63'd0, in_ready}, 64'd1);
      eq("R1 lines in reset", tx_lines, '0);
      eq("R1 ack in reset", {63'd0, rx_ack}, 64'd0);
      eq("R1 strobe in reset", {63'd0, out_valid}, 64'd0);
      eq("R1 err in reset", {63'd0, err_flag}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      eq("R1 lines after reset", tx_lines, '0);
      eq("R1 ready after reset", {63'd0, in_ready}, 64'd1);
   endtask

   task automatic t_patterns();
      send_word(32'h0000_0000);
      send_word(32'hFFFF_FFFF);
      send_word(32'h1B1B_1B1B);
      send_word(32'hA5A5_C33C);
   endtask

   task automatic t_stall();
      logic [W-1:0] w;
      w = 32'h5A0F_E1D2;
      ack_block = 1'b1;
      ack_force = 1'b0;
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      @(negedge clk);
      in_valid = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         eq("R4 hold while ack low", tx_lines, enc(w));
         eq("R3 ready low while busy", {63'd0, in_ready}, 64'd0);
      end
      ack_force = 1'b1;
      @(negedge clk);
      eq("R4 spacer after ack", tx_lines, '0);
      in_valid = 1'b1;
      in_word  = 32'h1234_5678;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         eq("R5 ready low while ack high", {63'd0, in_ready}, 64'd0);
         eq("R5 no new code", tx_lines, '0);
      end
      in_valid  = 1'b0;
      ack_force = 1'b0;
      @(negedge clk);
      eq("R5 ready after ack low", {63'd0, in_ready}, 64'd1);
      ack_block = 1'b0;
      eq("R8 rx ack low after spacer", {63'd0, rx_ack}, 64'd0);
   endtask

   task automatic t_partial();
      logic [L-1:0] code;
      code = enc(32'h9C3E_7104);
      ack_block = 1'b1;
      ack_force = 1'b0;
      inj_en    = 1'b1;
      @(negedge clk);
      inj_val = code & ~(64'hF << 12);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         eq("R7 no ack on partial code", {63'd0, rx_ack}, 64'd0);
         eq("R7 no strobe on partial code", {63'd0, out_valid}, 64'd0);
      end
      inj_val = code;
      @(negedge clk);
      eq("R6 ack on completion", {63'd0, rx_ack}, 64'd1);
      eq("R6 word on completion", {32'd0, out_word}, 64'h9C3E_7104);
      inj_val = code & ~64'hF;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         eq("R8 ack held while lines high", {63'd0, rx_ack}, 64'd1);
         eq("R6 no repeat strobe", {63'd0, out_valid}, 64'd0);
      end
      inj_val = '0;
      @(negedge clk);
      eq("R8 ack falls after all low", {63'd0, rx_ack}, 64'd0);
   endtask

   task automatic t_multi();
      logic [L-1:0] code;
      code = enc(32'h0F0F_3333);
      @(negedge clk);
      inj_val = code | (64'hF << 8);
      @(negedge clk);
      eq("R9 err set", {63'd0, err_flag}, 64'd1);
      for (int i = 0; i < 3; i++) begin
         eq("R9 no ack on multi-hot", {63'd0, rx_ack}, 64'd0);
         eq("R9 no strobe on multi-hot", {63'd0, out_valid}, 64'd0);
         @(negedge clk);
      end
      inj_val = '0;
      @(negedge clk);
      eq("R9 err sticky after clear", {63'd0, err_flag}, 64'd1);
      inj_val = code;
      @(negedge clk);
      eq("R9 good code accepted afterwards", {32'd0, out_word}, 64'h0F0F_3333);
      eq("R9 err still set", {63'd0, err_flag}, 64'd1);
      inj_val = '0;
      @(negedge clk);
      @(negedge clk);
      inj_en    = 1'b0;
      ack_block = 1'b0;
      send_word(32'hC0DE_0001);
      eq("R9 err kept over transfer", {63'd0, err_flag}, 64'd1);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_patterns();
      t_stall();
      t_partial();
      t_multi();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule